// File: doc/BRIEF.md
# Configuration Request Descriptor Engine

This block lets a host turn a few register writes into one PCIe configuration read or write toward a configuration-space target. Software programs a header word, a byte-enable word, an address word and a write-data word, then triggers the engine. The engine decodes the request type and the bus, device/function and register offset from these words. For writes it compacts sparse byte enables into a contiguous access of the right length and address. It then issues the request on a simple request/response port and holds it until the target answers.

When the response arrives, the engine finishes the request. For a read it captures the returned data. If the target reports that no device answered, it loads all ones instead. It then sets the completion, idle and done status bits. A second programming path fills a three-entry staging buffer through one data port. A separate fire command then issues the request from that buffer, so software can write the body words as a stream. While a request is outstanding the engine is busy, and it ignores further triggers.

Top module: `cfgq_engine`

## Requirements
- R1: After reset, the status word (address 4), the read-data word (address 7) and the done word (address 8) read as zero, and no request is outstanding.
- R2: The header word (address 0) holds the request type in bits 31:24. 0x04 and 0x05 are reads, and 0x44 and 0x45 are writes. A read issues a 4-byte request at byte address {word2[11:2],2'b00}, with bus from word2[31:24] and device/function from word2[23:16]. The response data is loaded into the read-data word only when the response is valid and the device is present. A completed write to a present device leaves the read-data word unchanged.
- R3: A bus number equal to the ROOT_BUS parameter (default 0x80) goes out on the request port as bus 0. Any other bus number goes out unchanged.
- R4: A response that reports no device loads 0xFFFFFFFF into the read-data word, for reads and for writes.
- R5: For writes, the byte enables are bits 3:0 of word 1 (address 1). The request length is the number of set enables. The enabled bytes of the write data (address 3) are packed toward bit 0 in ascending byte order. The byte address is advanced by the index of the lowest enabled byte. Enables of 0xF give an unchanged aligned 32-bit write.
- R6: A write whose byte enables are all zero issues no request, but it still completes.
- R7: A request type other than the four valid codes issues no request, but it still completes.
- R8: Writing bit 0 of the status word starts a request. On completion, status bit 31 (idle) and bit 25 (complete) are set, and bit 0 of the done word is set. Status bit 8 reads 1 while a request is outstanding.
- R9: Writing 1 to bit 0 of the clear word (address 5) clears the idle bit. The complete bit is left alone.
- R10: Writing 1 to bit 4 of the control word (address 6) loads 0xFFFFFFFF into the read-data word.
- R11: Writing 1 to bit 0 of the done word clears both the done bit and the complete bit.
- R12: Each write to the staging port (address 9) stores one word at the staging index and advances the index, which wraps after three entries. Writing bit 0 of the fire word (address 10) issues a request. This request uses the header word, with staged entry 0 as word 1, entry 1 as word 2 and entry 2 as write data. The fire command also resets the staging index to 0.
- R13: While a request is outstanding, its port fields stay stable, and triggers and fire commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address for writes and reads |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data of the word at reg_addr, one cycle later |
| req_valid | output | 1 | Request outstanding toward the target |
| req_write | output | 1 | Request is a write |
| req_bus | output | 8 | Target bus number after root aliasing |
| req_devfn | output | 8 | Target device/function |
| req_addr | output | 12 | Byte address in configuration space |
| req_len | output | LEN_W | Access length in bytes |
| req_wdata | output | DW | Packed write data |
| rsp_valid | input | 1 | Target response strobe |
| rsp_present | input | 1 | Target device exists |
| rsp_rdata | input | DW | Target read data |

## Verification
The bench drives sparse enable patterns where the packing logic is easy to get wrong. One is 0x6, where the bytes are contiguous but offset, and another is 0xA, where they have a gap. With these, a packer that shifts instead of compacting shows a wrong address, length or data on the port. Root-bus aliasing is tested against a neighbouring bus number, so that an over-broad compare is caught. The all-zero enable case and an illegal type code must complete without a request, and a design that issues one shows up as an unexpected item at the scoreboard.

The staging buffer is filled four times before a fire, which tests the wrap. It is then refilled after the fire, so an index that is not reset scrambles the second request. A second trigger is sent while a slow response is pending. A design that does not block it, or that latches read data before the response, issues an extra request or shows early data.

// File: rtl/cfgq_pkg.sv
package cfgq_pkg;
  localparam int BUS_W = 8;
  localparam int FN_W  = 8;
  localparam int OFF_W = 12;

  // register word addresses
  localparam int A_HDR   = 0;
  localparam int A_BE    = 1;
  localparam int A_ADR   = 2;
  localparam int A_WDAT  = 3;
  localparam int A_STAT  = 4;
  localparam int A_CLR   = 5;
  localparam int A_CTL   = 6;
  localparam int A_RDAT  = 7;
  localparam int A_DONE  = 8;
  localparam int A_STAGE = 9;
  localparam int A_FIRE  = 10;

  localparam int ST_IDLE_BIT = 31;
  localparam int ST_CMPL_BIT = 25;
  localparam int ST_BUSY_BIT = 8;
  localparam int CTL_ONES_BIT = 4;

  typedef enum logic [7:0] {
    FT_RD0 = 8'h04,
    FT_RD1 = 8'h05,
    FT_WR0 = 8'h44,
    FT_WR1 = 8'h45
  } fmt_e;

  typedef struct packed {
    logic legal;
    logic write;
  } kind_t;

  function automatic kind_t classify(input logic [7:0] code);
    kind_t k;
    k.legal = (code == FT_RD0) || (code == FT_RD1) ||
              (code == FT_WR0) || (code == FT_WR1);
    k.write = (code == FT_WR0) || (code == FT_WR1);
    return k;
  endfunction
endpackage

// File: rtl/cfgq_byte_pack.sv
module cfgq_byte_pack #(
  parameter int NB    = 4,
  parameter int LEN_W = $clog2(NB + 1),
  parameter int FW    = $clog2(NB)
) (
  input  logic [NB-1:0]   be_i,
  input  logic [8*NB-1:0] data_i,
  output logic [LEN_W-1:0] len_o,
  output logic [FW-1:0]    first_o,
  output logic [8*NB-1:0]  packed_o
);
  always_comb begin
    int unsigned cnt;
    logic seen;
    cnt      = 0;
    seen     = 1'b0;
    packed_o = '0;
    first_o  = '0;
    for (int i = 0; i < NB; i++) begin
      if (be_i[i]) begin
        packed_o[8*cnt +: 8] = data_i[8*i +: 8];
        if (!seen) first_o = FW'(i);
        seen = 1'b1;
        cnt  = cnt + 1;
      end
    end
    len_o = LEN_W'(cnt);
  end
endmodule

// File: rtl/cfgq_stage_buf.sv
module cfgq_stage_buf #(
  parameter int W     = 32,
  parameter int DEPTH = 3,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             rewind_i,
  output logic [DEPTH*W-1:0] flat_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (push_i) mem[idx] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst || rewind_i) idx <= '0;
    else if (push_i) idx <= (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_out
    assign flat_o[k*W +: W] = mem[k];
  end

  assert_idx_range_R12: assert property (@(posedge clk) disable iff (rst)
    (32'(idx) < DEPTH));
endmodule

// File: rtl/cfgq_engine.sv
module cfgq_engine
  import cfgq_pkg::*;
#(
  parameter int DW          = 32,
  parameter int REG_AW      = 4,
  parameter int STAGE_DEPTH = 3,
  parameter logic [7:0] ROOT_BUS = 8'h80,
  localparam int NB    = DW / 8,
  localparam int LEN_W = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              req_valid,
  output logic              req_write,
  output logic [BUS_W-1:0]  req_bus,
  output logic [FN_W-1:0]   req_devfn,
  output logic [OFF_W-1:0]  req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [DW-1:0]     req_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_present,
  input  logic [DW-1:0]     rsp_rdata
);
  localparam int FW = $clog2(NB);

  logic [DW-1:0] hdr_q, be_q, adr_q, wdat_q, rdata_q;
  logic st_idle, st_cmpl, done_q;

  function automatic logic hit(input logic [REG_AW-1:0] a, input int off);
    return a == REG_AW'(off);
  endfunction

  logic wr_stat, wr_clr, wr_ctl, wr_done, wr_stage, wr_fire;
  assign wr_stat  = reg_wr && hit(reg_addr, A_STAT);
  assign wr_clr   = reg_wr && hit(reg_addr, A_CLR);
  assign wr_ctl   = reg_wr && hit(reg_addr, A_CTL);
  assign wr_done  = reg_wr && hit(reg_addr, A_DONE);
  assign wr_stage = reg_wr && hit(reg_addr, A_STAGE);
  assign wr_fire  = reg_wr && hit(reg_addr, A_FIRE);

  logic trig_reg, trig_stage, trig;
  assign trig_reg   = wr_stat && reg_wdata[0] && !req_valid;
  assign trig_stage = wr_fire && reg_wdata[0] && !req_valid;
  assign trig       = trig_reg || trig_stage;

  // staging buffer
  logic [STAGE_DEPTH*DW-1:0] stage_flat;
  cfgq_stage_buf #(.W(DW), .DEPTH(STAGE_DEPTH)) u_stage (
    .clk(clk), .rst(rst), .push_i(wr_stage), .din_i(reg_wdata),
    .rewind_i(trig_stage), .flat_o(stage_flat)
  );

  // source selection
  logic [DW-1:0] sel_w1, sel_w2, sel_wd;
  assign sel_w1 = trig_stage ? stage_flat[0*DW +: DW] : be_q;
  assign sel_w2 = trig_stage ? stage_flat[1*DW +: DW] : adr_q;
  assign sel_wd = trig_stage ? stage_flat[2*DW +: DW] : wdat_q;

  kind_t kind;
  assign kind = classify(hdr_q[31:24]);

  logic [BUS_W-1:0] bus_raw, bus_map;
  assign bus_raw = sel_w2[31:24];
  assign bus_map = (bus_raw == ROOT_BUS) ? '0 : bus_raw;

  logic [OFF_W-1:0] dw_off;
  assign dw_off = {sel_w2[11:2], 2'b00};

  logic [LEN_W-1:0] pk_len;
  logic [FW-1:0]    pk_first;
  logic [DW-1:0]    pk_data;
  cfgq_byte_pack #(.NB(NB), .LEN_W(LEN_W), .FW(FW)) u_pack (
    .be_i(sel_w1[NB-1:0]), .data_i(sel_wd),
    .len_o(pk_len), .first_o(pk_first), .packed_o(pk_data)
  );

  logic issue;
  assign issue = kind.legal && (!kind.write || pk_len != '0);

  logic unused_bits;
  assign unused_bits = ^{sel_w1[DW-1:NB], sel_w2[15:12], sel_w2[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q <= '0; be_q <= '0; adr_q <= '0; wdat_q <= '0; rdata_q <= '0;
      st_idle <= 1'b0; st_cmpl <= 1'b0; done_q <= 1'b0;
      req_valid <= 1'b0; req_write <= 1'b0; req_bus <= '0; req_devfn <= '0;
      req_addr <= '0; req_len <= '0; req_wdata <= '0;
    end else begin
      if (reg_wr && hit(reg_addr, A_HDR))  hdr_q  <= reg_wdata;
      if (reg_wr && hit(reg_addr, A_BE))   be_q   <= reg_wdata;
      if (reg_wr && hit(reg_addr, A_ADR))  adr_q  <= reg_wdata;
      if (reg_wr && hit(reg_addr, A_WDAT)) wdat_q <= reg_wdata;
      if (wr_clr && reg_wdata[0]) st_idle <= 1'b0;
      if (wr_done && reg_wdata[0]) begin
        done_q  <= 1'b0;
        st_cmpl <= 1'b0;
      end
      if (wr_ctl && reg_wdata[CTL_ONES_BIT]) rdata_q <= '1;

      if (trig) begin
        if (issue) begin
          req_valid <= 1'b1;
          req_write <= kind.write;
          req_bus   <= bus_map;
          req_devfn <= sel_w2[23:16];
          req_addr  <= kind.write ? dw_off + OFF_W'(pk_first) : dw_off;
          req_len   <= kind.write ? pk_len : LEN_W'(NB);
          req_wdata <= kind.write ? pk_data : '0;
        end else begin
          st_idle <= 1'b1;
          st_cmpl <= 1'b1;
          done_q  <= 1'b1;
        end
      end

      if (req_valid && rsp_valid) begin
        req_valid <= 1'b0;
        st_idle   <= 1'b1;
        st_cmpl   <= 1'b1;
        done_q    <= 1'b1;
        if (!rsp_present)    rdata_q <= '1;
        else if (!req_write) rdata_q <= rsp_rdata;
      end
    end
  end

  // registered readback
  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      reg_rdata <= '0;
      case (32'(reg_addr))
        A_HDR:  reg_rdata <= hdr_q;
        A_BE:   reg_rdata <= be_q;
        A_ADR:  reg_rdata <= adr_q;
        A_WDAT: reg_rdata <= wdat_q;
        A_STAT: begin
          reg_rdata[ST_IDLE_BIT] <= st_idle;
          reg_rdata[ST_CMPL_BIT] <= st_cmpl;
          reg_rdata[ST_BUSY_BIT] <= req_valid;
        end
        A_RDAT: reg_rdata <= rdata_q;
        A_DONE: reg_rdata[0] <= done_q;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !rsp_valid) |=> (req_valid && $stable(req_addr) &&
      $stable(req_bus) && $stable(req_wdata) && $stable(req_len)));

  assert_len_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_len != '0 && 32'(req_len) <= NB));

  assert_finish_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rsp_valid) |=> (st_idle && st_cmpl && done_q && !req_valid));

  assert_alias_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (ROOT_BUS == '0 || req_bus != ROOT_BUS));

  assert_absent_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rsp_valid && !rsp_present) |=> (rdata_q == '1));
endmodule

// File: tb/tb_cfgq_engine.sv
module tb_cfgq_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_write;
  logic [7:0]  req_bus, req_devfn;
  logic [11:0] req_addr;
  logic [2:0]  req_len;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0, rsp_present = 1'b0;
  logic [31:0] rsp_rdata = '0;

  cfgq_engine dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
    .req_devfn(req_devfn), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_present(rsp_present),
    .rsp_rdata(rsp_rdata)
  );

  typedef struct {
    bit          wr;
    logic [7:0]  bus, devfn;
    logic [11:0] addr;
    logic [2:0]  len;
    logic [31:0] wdata;
    bit          present;
    logic [31:0] rdata;
    int          dly;
    string       tag;
  } item_t;

  item_t expq[$];
  int compared = 0, mismatched = 0, req_seen = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic expect_req(input bit wr, input logic [7:0] bus, input logic [7:0] devfn,
                            input logic [11:0] addr, input logic [2:0] len,
                            input logic [31:0] wd, input bit present,
                            input logic [31:0] rd, input int dly, input string tag);
    item_t it;
    it.wr = wr; it.bus = bus; it.devfn = devfn; it.addr = addr; it.len = len;
    it.wdata = wd; it.present = present; it.rdata = rd; it.dly = dly; it.tag = tag;
    expq.push_back(it);
  endtask

  // monitor / target model
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        req_seen++;
        if (expq.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R6/R7/R13 unexpected request: got addr %h expected none", req_addr);
          rsp_present = 1'b1; rsp_rdata = '0;
        end else begin
          item_t it;
          it = expq.pop_front();
          chk({it.tag, " write flag"}, 32'(req_write), 32'(it.wr));
          chk({it.tag, " bus"}, 32'(req_bus), 32'(it.bus));
          chk({it.tag, " devfn"}, 32'(req_devfn), 32'(it.devfn));
          chk({it.tag, " addr"}, 32'(req_addr), 32'(it.addr));
          chk({it.tag, " len"}, 32'(req_len), 32'(it.len));
          chk({it.tag, " wdata"}, req_wdata, it.wdata);
          rsp_present = it.present; rsp_rdata = it.rdata;
          repeat (it.dly) @(negedge clk);
        end
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'h100;
    while (s[8] || expq.size() != 0) rd(4, s);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] w0, input logic [31:0] w1,
                     input logic [31:0] w2, input logic [31:0] wd);
    wr(0, w0); wr(1, w1); wr(2, w2); wr(3, wd); wr(4, 32'h1);
    wait_idle();
  endtask

  function automatic void pack_model(input logic [3:0] be, input logic [31:0] d,
                                     input logic [11:0] off, output logic [11:0] a,
                                     output logic [2:0] n, output logic [31:0] p);
    int k = 0, f = -1;
    p = '0;
    for (int i = 0; i < 4; i++) if (be[i]) begin
      p[8*k +: 8] = d[8*i +: 8];
      if (f < 0) f = i;
      k++;
    end
    n = 3'(k);
    a = off + 12'(f < 0 ? 0 : f);
  endfunction

  logic [31:0] v;
  int cnt0;

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [11:0] ea; logic [2:0] en; logic [31:0] ep;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(4, v); chk("R1 status", v, 0);
    rd(7, v); chk("R1 rdata", v, 0);
    rd(8, v); chk("R1 done", v, 0);
    chk("R1 req_valid", 32'(req_valid), 0);

    // R2 type-0 read, R8 status
    expect_req(0, 8'h03, 8'h10, 12'h0A8, 3'd4, 0, 1, 32'hCAFE0001, 2, "R2 read");
    run(32'h04000000, 0, 32'h031000A8, 0);
    rd(7, v); chk("R2 rdata", v, 32'hCAFE0001);
    rd(4, v); chk("R8 status idle+complete", v, 32'h82000000);
    rd(8, v); chk("R8 done", v, 1);
    // R9 clear idle
    wr(5, 1); rd(4, v); chk("R9 idle cleared", v, 32'h02000000);
    // R11 clear done clears complete
    wr(8, 1); rd(8, v); chk("R11 done cleared", v, 0);
    rd(4, v); chk("R11 complete cleared", v, 0);

    // R3 alias, R4 missing device on read
    expect_req(0, 8'h00, 8'h08, 12'h000, 3'd4, 0, 0, 32'h1, 1, "R3 alias");
    run(32'h05000000, 0, 32'h80080000, 0);
    rd(7, v); chk("R4 absent read ones", v, 32'hFFFFFFFF);
    expect_req(0, 8'h81, 8'h00, 12'h100, 3'd4, 0, 1, 32'h12345678, 1, "R3 non-root");
    run(32'h05000000, 0, 32'h81000100, 0);
    rd(7, v); chk("R2 rdata non-root", v, 32'h12345678);

    // R5 packing
    pack_model(4'h6, 32'hAABBCCDD, 12'h010, ea, en, ep);
    chk("R5 model sanity be6", ep, 32'h0000BBCC);
    expect_req(1, 8'h01, 8'h00, ea, en, ep, 1, 0, 1, "R5 be6");
    run(32'h44000000, 32'h6, 32'h01000010, 32'hAABBCCDD);
    rd(7, v); chk("R2 write leaves rdata", v, 32'h12345678);
    pack_model(4'hA, 32'h11223344, 12'h020, ea, en, ep);
    expect_req(1, 8'h01, 8'h00, ea, en, ep, 1, 0, 0, "R5 beA");
    run(32'h45000000, 32'hA, 32'h01000020, 32'h11223344);
    pack_model(4'hF, 32'h11223344, 12'h024, ea, en, ep);
    expect_req(1, 8'h01, 8'h00, ea, en, ep, 1, 0, 0, "R5 beF");
    run(32'h44000000, 32'hF, 32'h01000024, 32'h11223344);
    pack_model(4'h8, 32'h11223344, 12'h028, ea, en, ep);
    expect_req(1, 8'h01, 8'h00, ea, en, ep, 1, 0, 0, "R5 be8");
    run(32'h44000000, 32'h8, 32'h01000028, 32'h11223344);

    // R6 zero enables: no request but completes
    wr(5, 1); wr(8, 1);
    cnt0 = req_seen;
    run(32'h44000000, 32'h0, 32'h01000030, 32'h55);
    chk("R6 no request", 32'(req_seen), 32'(cnt0));
    rd(4, v); chk("R6 completes", v, 32'h82000000);
    rd(7, v); chk("R6 rdata unchanged", v, 32'h12345678);
    // R7 illegal type
    wr(5, 1); wr(8, 1);
    cnt0 = req_seen;
    run(32'h24000000, 32'hF, 32'h01000030, 32'h55);
    chk("R7 no request", 32'(req_seen), 32'(cnt0));
    rd(8, v); chk("R7 completes", v, 1);

    // R4 missing device on write
    expect_req(1, 8'h02, 8'h00, 12'h040, 3'd4, 32'h9, 0, 0, 0, "R4 absent write");
    run(32'h44000000, 32'hF, 32'h02000040, 32'h9);
    rd(7, v); chk("R4 absent write ones", v, 32'hFFFFFFFF);

    // R10 control forces ones
    expect_req(0, 8'h02, 8'h00, 12'h044, 3'd4, 0, 1, 32'h5555AAAA, 0, "R10 setup");
    run(32'h04000000, 0, 32'h02000044, 0);
    rd(7, v); chk("R10 before", v, 32'h5555AAAA);
    wr(6, 32'h10); rd(7, v); chk("R10 forced ones", v, 32'hFFFFFFFF);

    // R12 staging with wrap, fire, index rewind
    wr(0, 32'h04000000);
    wr(9, 32'hFFFFFFFF); wr(9, 32'h02080040); wr(9, 32'h0); wr(9, 32'h0000000F);
    expect_req(0, 8'h02, 8'h08, 12'h040, 3'd4, 0, 1, 32'h77770001, 1, "R12 wrap fire");
    wr(10, 1); wait_idle();
    rd(7, v); chk("R12 staged read data", v, 32'h77770001);
    wr(0, 32'h44000000);
    wr(9, 32'h3); wr(9, 32'h01020004); wr(9, 32'hDEADBEEF);
    expect_req(1, 8'h01, 8'h02, 12'h004, 3'd2, 32'h0000BEEF, 1, 0, 1, "R12 rewind fire");
    wr(10, 1); wait_idle();

    // R13 busy blocks triggers, data latched only on response
    cnt0 = req_seen;
    expect_req(0, 8'h05, 8'h00, 12'h0FC, 3'd4, 0, 1, 32'h0BADF00D, 20, "R13 slow");
    wr(0, 32'h04000000); wr(2, 32'h050000FC); wr(4, 1);
    wr(2, 32'h06000000); wr(4, 1); wr(10, 1);
    rd(4, v); chk("R13 busy flag", 32'(v[8]), 1);
    rd(7, v); chk("R13 rdata before response", v, 32'h77770001);
    wait_idle();
    chk("R13 single request", 32'(req_seen - cnt0), 1);
    rd(7, v); chk("R13 rdata after response", v, 32'h0BADF00D);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule